// File: doc/BRIEF.md
# Fully-Associative Address Translation Buffer with Address-Space Tags

This block caches virtual-to-physical page translations for a 32-bit virtual space with 4 KB pages. Each of its slots can hold any translation. A lookup presents a virtual address, an access type and the current address-space tag. All slots are compared at once. The result comes back in the same cycle as a hit, a miss or a protection fault. On an allowed hit the block also gives the physical address.

New translations arrive on an insert port. If the key is already present, that slot is rewritten. Otherwise the block takes a free slot if one exists. When every slot is valid, it evicts a victim chosen by one of two policies, picked by a configuration input: least recently used, or a pseudo-random start point. Slots inserted as pinned are never evicted and survive a flush. The flush input drops every other translation in one cycle, which suits a context switch done without address-space tags.

Top module: `tlb_fa_asid`

## Requirements
- R1: A lookup hits only on a slot that is valid and whose stored 20-bit page number and 8-bit address-space tag both equal the lookup's. The same page number under two different tags gives two independent translations.
- R2: On a hit whose access is allowed, `paddr` equals the slot's frame number in bits 31:12 and `lk_vaddr[11:0]` in bits 11:0. It is valid in the same cycle as the lookup.
- R3: Permission bits are bit 0 read, bit 1 write and bit 2 execute. The access code is 0 read, 1 write, 2 execute; code 3 always faults. On a hit where the access is not permitted, `hit`=1, `prot_fault`=1 and `paddr`=0.
- R4: `miss`=1 when `lk_valid`=1 and no slot matches. When `lk_valid`=0, `hit`, `miss`, `prot_fault`, `hit_dirty` and `paddr` are all 0.
- R5: Inserting a key (page number and tag) that is already present rewrites that slot. No other translation is lost.
- R6: While any slot is invalid, an insert of a new key fills an invalid slot and evicts no valid translation.
- R7: With `policy`=0 and all slots valid, a new key replaces the non-pinned slot touched least recently. A slot is touched by a lookup hit or by an insert written into it.
- R8: With `policy`=1 and all slots valid, the victim is found from a free-running 8-bit LFSR. The scan starts at the LFSR value modulo the slot count and moves upward, wrapping, to the first non-pinned slot. Exactly one translation is replaced.
- R9: A slot inserted with `ins_pin`=1 is never evicted, whichever policy is selected. An insert of a new key when every slot is valid and pinned is dropped.
- R10: One cycle after `flush`=1, every non-pinned slot is invalid and pinned slots still hit. An insert in the same cycle as a flush is dropped.
- R11: Each slot stores a dirty bit. `hit_dirty` shows it on a hit.
- R12: After reset every slot is invalid and unpinned, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_access | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| cur_asid | input | 8 | Current address-space tag |
| hit | output | 1 | A valid slot matched |
| miss | output | 1 | No slot matched |
| prot_fault | output | 1 | Matched, but access not permitted |
| hit_dirty | output | 1 | Dirty bit of the matched slot |
| paddr | output | 32 | Physical address on an allowed hit, else 0 |
| ins_en | input | 1 | Write a translation this cycle |
| ins_vpn | input | 20 | Page number to insert |
| ins_asid | input | 8 | Tag to insert |
| ins_pfn | input | 20 | Frame number to insert |
| ins_perm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| ins_dirty | input | 1 | Dirty bit to insert |
| ins_pin | input | 1 | Mark the slot as never evictable |
| flush | input | 1 | Invalidate all non-pinned slots |
| policy | input | 1 | Victim policy: 0 least recently used, 1 random |

## Verification
The bench looks up one page number under two tags. A design that ignored the tag would return the wrong frame or hit across address spaces. It rewrites a key already present in a full buffer and then looks up every key. A design that treated the rewrite as a new insert would evict a valid translation or keep a stale duplicate. The LRU and random runs use pinned slots that the policy would otherwise pick: the oldest slot under LRU, and every slot but one under random. A broken skip would make a pinned translation miss. Flush is checked on its own and combined with an insert, and a fully pinned buffer is checked against a new key. A wrong priority would leave a non-pinned entry alive or overwrite a pinned one.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W   = 32;
  localparam int OFF_W  = 12;
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int PFN_W  = 20;
  localparam int PA_W   = PFN_W + OFF_W;
  localparam int LFSR_W = 8;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  // bit 0 read, bit 1 write, bit 2 execute
  typedef logic [2:0] perm_t;

  function automatic logic perm_allows(perm_t perm, logic [1:0] acc);
    case (acc)
      ACC_READ:  return perm[0];
      ACC_WRITE: return perm[1];
      ACC_EXEC:  return perm[2];
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic [PA_W-1:0] make_paddr(logic [PFN_W-1:0] pfn,
                                                 logic [OFF_W-1:0] off);
    return {pfn, off};
  endfunction

  // x^8 + x^6 + x^5 + x^4 + 1, shift toward the MSB
  function automatic logic [LFSR_W-1:0] lfsr_step(logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N     = 8,
  parameter int KEY_W = 28,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]            ent_valid,
  input  logic [N-1:0][KEY_W-1:0] ent_key,
  input  logic [KEY_W-1:0]        probe,
  output logic [N-1:0]            hit_vec,
  output logic                    any,
  output logic [IDX_W-1:0]        idx
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_vec[i] = ent_valid[i] && (ent_key[i] == probe);
  end

  assign any = |hit_vec;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++)
      if (hit_vec[i]) idx = IDX_W'(i);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
  import tlb_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid,
  input  logic [N-1:0]     pin,
  input  logic             policy,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] victim_idx,
  output logic             victim_ok
);
  logic [N-1:0][IDX_W-1:0] age_q;
  logic [LFSR_W-1:0]       lfsr_q;

  logic             any_free, lru_found, rnd_found;
  logic [IDX_W-1:0] free_idx, lru_idx, rnd_idx;

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (!valid[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
  end

  always_comb begin
    lru_found = 1'b0;
    lru_idx   = '0;
    for (int i = 0; i < N; i++)
      if (!pin[i] && (!lru_found || age_q[i] > age_q[lru_idx])) begin
        lru_found = 1'b1;
        lru_idx   = IDX_W'(i);
      end
  end

  always_comb begin
    int start;
    int j;
    start     = int'(lfsr_q) % N;
    rnd_found = 1'b0;
    rnd_idx   = '0;
    for (int k = 0; k < N; k++) begin
      j = (start + k) % N;
      if (!rnd_found && !pin[j]) begin
        rnd_found = 1'b1;
        rnd_idx   = IDX_W'(j);
      end
    end
  end

  assign victim_ok  = any_free || lru_found;
  assign victim_idx = any_free ? free_idx : (policy ? rnd_idx : lru_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr_q <= LFSR_W'(1);
      for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(i);
    end else begin
      lfsr_q <= lfsr_step(lfsr_q);
      if (touch_en)
        for (int i = 0; i < N; i++)
          if (IDX_W'(i) == touch_idx) age_q[i] <= '0;
          else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
    end
  end

  // R6
  free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_free |-> !valid[victim_idx]);

  // R9
  victim_unpinned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (victim_ok && !any_free) |-> !pin[victim_idx]);
endmodule

// File: rtl/tlb_fa_asid.sv
module tlb_fa_asid
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ASID_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic [1:0]       lk_access,
  input  logic [ASID_W-1:0] cur_asid,
  output logic             hit,
  output logic             miss,
  output logic             prot_fault,
  output logic             hit_dirty,
  output logic [PA_W-1:0]  paddr,
  input  logic             ins_en,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic [ASID_W-1:0] ins_asid,
  input  logic [PFN_W-1:0] ins_pfn,
  input  logic [2:0]       ins_perm,
  input  logic             ins_dirty,
  input  logic             ins_pin,
  input  logic             flush,
  input  logic             policy
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int KEY_W = ASID_W + VPN_W;

  logic [ENTRIES-1:0]             valid_q, pin_q, dirty_q;
  logic [ENTRIES-1:0][KEY_W-1:0]  key_q;
  logic [ENTRIES-1:0][PFN_W-1:0]  pfn_q;
  logic [ENTRIES-1:0][2:0]        perm_q;

  // lookup side
  logic [ENTRIES-1:0] lk_vec;
  logic               lk_any, lk_ok;
  logic [IDX_W-1:0]   lk_idx;

  tlb_match #(.N(ENTRIES), .KEY_W(KEY_W)) u_lk_match (
    .ent_valid(valid_q), .ent_key(key_q),
    .probe({cur_asid, lk_vaddr[VA_W-1:OFF_W]}),
    .hit_vec(lk_vec), .any(lk_any), .idx(lk_idx));

  assign lk_ok      = perm_allows(perm_q[lk_idx], lk_access);
  assign hit        = lk_valid && lk_any;
  assign miss       = lk_valid && !lk_any;
  assign prot_fault = hit && !lk_ok;
  assign hit_dirty  = hit && dirty_q[lk_idx];
  assign paddr      = (hit && lk_ok) ? make_paddr(pfn_q[lk_idx], lk_vaddr[OFF_W-1:0]) : '0;

  // insert side
  logic [ENTRIES-1:0] ins_vec;
  logic               ins_any, vic_ok, wr_fire, evict_fire, touch_en;
  logic [IDX_W-1:0]   ins_idx, vic_idx, wr_idx, touch_idx;

  tlb_match #(.N(ENTRIES), .KEY_W(KEY_W)) u_ins_match (
    .ent_valid(valid_q), .ent_key(key_q), .probe({ins_asid, ins_vpn}),
    .hit_vec(ins_vec), .any(ins_any), .idx(ins_idx));

  assign wr_fire    = ins_en && !flush && (ins_any || vic_ok);
  assign wr_idx     = ins_any ? ins_idx : vic_idx;
  assign evict_fire = wr_fire && !ins_any && valid_q[wr_idx];
  assign touch_en   = wr_fire || hit;
  assign touch_idx  = wr_fire ? wr_idx : lk_idx;

  tlb_victim #(.N(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid(valid_q), .pin(pin_q), .policy(policy),
    .touch_en(touch_en), .touch_idx(touch_idx),
    .victim_idx(vic_idx), .victim_ok(vic_ok));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      pin_q   <= '0;
      dirty_q <= '0;
      key_q   <= '0;
      pfn_q   <= '0;
      perm_q  <= '0;
    end else if (flush) begin
      valid_q <= valid_q & pin_q;
    end else if (wr_fire) begin
      valid_q[wr_idx] <= 1'b1;
      pin_q[wr_idx]   <= pin_q[wr_idx] | ins_pin;
      dirty_q[wr_idx] <= ins_dirty;
      key_q[wr_idx]   <= {ins_asid, ins_vpn};
      pfn_q[wr_idx]   <= ins_pfn;
      perm_q[wr_idx]  <= ins_perm;
    end
  end

  // R1
  unique_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_vec));

  // R3
  fault_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_fault |-> (hit && paddr == '0));

  // R9
  pin_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evict_fire |-> !pin_q[wr_idx]);

  // R9
  pin_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(valid_q & pin_q) & ~valid_q) == '0));

  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ((valid_q & ~pin_q) == '0));
endmodule

// File: tb/sim_tlb_fa_asid.sv
`timescale 1ns/1ps
module sim_tlb_fa_asid;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0, ins_en = 1'b0, ins_dirty = 1'b0, ins_pin = 1'b0;
  logic flush = 1'b0, policy = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [1:0]  lk_access = '0;
  logic [7:0]  cur_asid = '0, ins_asid = '0;
  logic [19:0] ins_vpn = '0, ins_pfn = '0;
  logic [2:0]  ins_perm = '0;
  logic hit, miss, prot_fault, hit_dirty;
  logic [31:0] paddr;

  int n_cmp = 0, n_bad = 0;
  logic r_hit, r_miss, r_pf, r_dirty;
  logic [31:0] r_pa;

  always #2.5 clk = ~clk;

  tlb_fa_asid u0 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_access(lk_access), .cur_asid(cur_asid), .hit(hit), .miss(miss),
    .prot_fault(prot_fault), .hit_dirty(hit_dirty), .paddr(paddr),
    .ins_en(ins_en), .ins_vpn(ins_vpn), .ins_asid(ins_asid), .ins_pfn(ins_pfn),
    .ins_perm(ins_perm), .ins_dirty(ins_dirty), .ins_pin(ins_pin),
    .flush(flush), .policy(policy));

  function automatic logic [19:0] kv(int i); return 20'h10000 + 20'(i); endfunction
  function automatic logic [19:0] kp(int i); return 20'h30000 + 20'(i * 3); endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; policy = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic ins(logic [19:0] vpn, logic [7:0] asid, logic [19:0] pfn,
                     logic [2:0] perm, logic dirty, logic pin);
    @(negedge clk);
    ins_en = 1'b1; ins_vpn = vpn; ins_asid = asid; ins_pfn = pfn;
    ins_perm = perm; ins_dirty = dirty; ins_pin = pin;
    @(negedge clk);
    ins_en = 1'b0; ins_pin = 1'b0;
  endtask

  task automatic do_flush(logic with_ins);
    @(negedge clk);
    flush = 1'b1;
    if (with_ins) begin
      ins_en = 1'b1; ins_vpn = kv(9); ins_asid = 8'd1; ins_pfn = kp(9);
      ins_perm = 3'b111; ins_dirty = 1'b0; ins_pin = 1'b0;
    end
    @(negedge clk);
    flush = 1'b0; ins_en = 1'b0;
  endtask

  task automatic look(logic [31:0] va, logic [7:0] asid, logic [1:0] acc);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; cur_asid = asid; lk_access = acc;
    #1;
    r_hit = hit; r_miss = miss; r_pf = prot_fault; r_dirty = hit_dirty; r_pa = paddr;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic expect_hit(string req, int i, logic [11:0] off);
    look({kv(i), off}, 8'd1, 2'd0);
    check(req, {31'd0, r_hit}, 32'd1);
    check(req, r_pa, {kp(i), off});
  endtask

  task automatic expect_miss(string req, int i);
    look({kv(i), 12'h000}, 8'd1, 2'd0);
    check(req, {31'd0, r_miss}, 32'd1);
  endtask

  task automatic fill(int n, int n_pinned);
    for (int i = 0; i < n; i++) ins(kv(i), 8'd1, kp(i), 3'b111, 1'b0, i < n_pinned);
  endtask

  task automatic t_reset();
    do_reset();
    look({kv(0), 12'h0}, 8'd1, 2'd0);
    check("R12 miss after reset", {31'd0, r_miss}, 32'd1);
    check("R12 no hit after reset", {31'd0, r_hit}, 32'd0);
    #1;
    check("R4 idle outputs", {27'd0, hit, miss, prot_fault, hit_dirty, 1'b0}, 32'd0);
    check("R4 idle paddr", paddr, 32'd0);
  endtask

  task automatic t_basic();
    do_reset();
    ins(20'hABCDE, 8'd5, 20'h12345, 3'b111, 1'b0, 1'b0);
    look(32'hABCDE_9A7, 8'd5, 2'd0);
    check("R2 paddr", r_pa, 32'h12345_9A7);
    look(32'hABCDE_FFF, 8'd5, 2'd1);
    check("R2 paddr max offset", r_pa, 32'h12345_FFF);
    look(32'hABCDE_000, 8'd6, 2'd0);
    check("R1 other tag misses", {31'd0, r_miss}, 32'd1);
    look(32'hABCDF_000, 8'd5, 2'd0);
    check("R4 other page misses", {31'd0, r_miss}, 32'd1);
    check("R4 miss gives zero paddr", r_pa, 32'd0);
    ins(20'hABCDE, 8'd6, 20'h55555, 3'b111, 1'b0, 1'b0);
    look(32'hABCDE_010, 8'd6, 2'd0);
    check("R1 second tag frame", r_pa, 32'h55555_010);
    look(32'hABCDE_010, 8'd5, 2'd0);
    check("R1 first tag frame kept", r_pa, 32'h12345_010);
  endtask

  task automatic t_perm();
    do_reset();
    ins(20'h00100, 8'd2, 20'h00777, 3'b001, 1'b1, 1'b0);
    ins(20'h00200, 8'd2, 20'h00888, 3'b100, 1'b0, 1'b0);
    look(32'h00100_044, 8'd2, 2'd0);
    check("R3 read allowed", {30'd0, r_pf, r_hit}, 32'd1);
    check("R3 read paddr", r_pa, 32'h00777_044);
    check("R11 dirty shown", {31'd0, r_dirty}, 32'd1);
    look(32'h00100_044, 8'd2, 2'd1);
    check("R3 write faults", {30'd0, r_pf, r_hit}, 32'd3);
    check("R3 fault paddr zero", r_pa, 32'd0);
    look(32'h00100_044, 8'd2, 2'd2);
    check("R3 exec faults", {31'd0, r_pf}, 32'd1);
    look(32'h00200_008, 8'd2, 2'd2);
    check("R3 exec allowed", {31'd0, r_pf}, 32'd0);
    check("R3 exec paddr", r_pa, 32'h00888_008);
    check("R11 clean shown", {31'd0, r_dirty}, 32'd0);
    look(32'h00200_008, 8'd2, 2'd3);
    check("R3 reserved code faults", {31'd0, r_pf}, 32'd1);
  endtask

  task automatic t_update();
    do_reset();
    fill(8, 0);
    ins(kv(3), 8'd1, 20'h7AAAA, 3'b111, 1'b0, 1'b0);
    look({kv(3), 12'h321}, 8'd1, 2'd0);
    check("R5 rewritten frame", r_pa, {20'h7AAAA, 12'h321});
    for (int i = 0; i < 8; i++)
      if (i != 3) expect_hit("R5 R6 no translation lost", i, 12'h004);
  endtask

  task automatic t_lru();
    do_reset();
    fill(8, 0);
    look({kv(0), 12'h0}, 8'd1, 2'd0);
    ins(kv(8), 8'd1, kp(8), 3'b111, 1'b0, 1'b0);
    expect_miss("R7 oldest evicted", 1);
    expect_hit("R7 touched kept", 0, 12'h0);
    expect_hit("R7 new present", 8, 12'h0);
    expect_hit("R7 others kept", 2, 12'h0);
  endtask

  task automatic t_pin_flush();
    do_reset();
    fill(8, 1);
    ins(kv(8), 8'd1, kp(8), 3'b111, 1'b0, 1'b0);
    expect_hit("R9 pinned oldest kept", 0, 12'h0);
    expect_miss("R7 next oldest evicted", 1);
    do_flush(1'b0);
    expect_hit("R10 pinned survives flush", 0, 12'h0);
    expect_miss("R10 unpinned flushed", 2);
    expect_miss("R10 new entry flushed", 8);
    do_flush(1'b1);
    expect_miss("R10 insert during flush dropped", 9);
  endtask

  task automatic t_random();
    int kept;
    do_reset();
    fill(7, 7);
    ins(kv(7), 8'd1, kp(7), 3'b111, 1'b0, 1'b0);
    policy = 1'b1;
    ins(kv(8), 8'd1, kp(8), 3'b111, 1'b0, 1'b0);
    expect_miss("R8 only unpinned slot replaced", 7);
    expect_hit("R8 new present", 8, 12'h0);
    for (int i = 0; i < 7; i++) expect_hit("R9 pinned kept under random", i, 12'h0);
    do_reset();
    fill(8, 8);
    ins(kv(9), 8'd1, kp(9), 3'b111, 1'b0, 1'b0);
    expect_miss("R9 full pinned insert dropped", 9);
    expect_hit("R9 full pinned kept", 0, 12'h0);
    do_reset();
    fill(8, 0);
    policy = 1'b1;
    ins(kv(8), 8'd1, kp(8), 3'b111, 1'b0, 1'b0);
    kept = 0;
    for (int i = 0; i < 8; i++) begin
      look({kv(i), 12'h0}, 8'd1, 2'd0);
      if (r_hit) kept++;
    end
    check("R8 exactly one replaced", 32'(kept), 32'd7);
    expect_hit("R8 random insert present", 8, 12'h0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    t_reset();
    t_basic();
    t_perm();
    t_update();
    t_lru();
    t_pin_flush();
    t_random();
    finish_run();
  end
endmodule